// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial memory with 4096 bytes of storage. It runs on a fast system clock. It samples the external clock line and data line through synchronisers. It detects bus start and stop conditions and recognises its own device address. It then serves random, current-address and sequential reads, and page writes of up to 32 bytes. The data line is open-drain, so the block only ever asks for the line to be pulled low (`sda_low_o`). The board supplies the pull-up.

Write data is gathered in a page buffer. It is committed to the array when the stop that closes the write arrives. A self-timed busy period then starts, lasting `WR_CYCLES` clocks. During that period the slave refuses its address. A write-protect input guards the top quarter of the array. Three strap inputs select one of eight addresses, so up to eight slaves can share a bus.

The control state machine has eleven states:
- `ST_IDLE`: waiting for a start.
- `ST_DEV`: shifting in the device byte.
- `ST_DEV_ACK`: answering the device byte.
- `ST_AHI` and `ST_AHI_ACK`: the high address byte and its answer.
- `ST_ALO` and `ST_ALO_ACK`: the low address byte and its answer.
- `ST_WDAT` and `ST_WDAT_ACK`: each write data byte and its answer.
- `ST_RDAT`: shifting out a read byte.
- `ST_RDAT_ACK`: sampling the master's answer to a read byte.

Transitions fire on the synchronised falling edge of the clock line. The exceptions are start and stop:
- A start moves any state to `ST_DEV`.
- A stop moves any state to `ST_IDLE`.
- `ST_DEV_ACK` goes to `ST_RDAT` for a read, to `ST_AHI` for a write, or to `ST_IDLE` if the address was refused.
- `ST_RDAT_ACK` goes back to `ST_RDAT` when the master acknowledges, and to `ST_IDLE` when it does not.

Top module: `eeprom_twi_slave`

## Requirements
- R1: Before a start condition has been seen (falling data while the clock is high), clock pulses never cause the block to pull the data line low.
- R2: The device byte is matched as follows: bits [7:4] must equal 4'b1010, bits [3:1] must equal `dev_sel_i`, and bit 0 is 1 for read and 0 for write. On a mismatch the block leaves the data line released on the ninth clock and ignores the bus until the next start.
- R3: For each accepted device byte, address byte and write data byte, the block pulls the data line low during the ninth clock. Its output changes only while the synchronised clock line is low.
- R4: The word address is sent as two bytes. The low four bits of the first byte form address bits [11:8], and its upper four bits are ignored. The second byte forms address bits [7:0].
- R5: In a read, the byte at the current address is returned MSB first, and the address then advances by one. The address rolls over from 0xFFF to 0x000. A master acknowledge continues the read, and a master no-acknowledge ends it. A read that follows a start without a word address continues from the advanced address.
- R6: A write accepts up to 32 data bytes. The low five address bits wrap within the 32-byte page. Bytes reach the array only after the closing stop.
- R7: If `wp_i` is high when the closing stop arrives, write data aimed at addresses 0xC00 to 0xFFF is discarded. Addresses below 0xC00 are written normally. With `wp_i` low, every address can be written.
- R8: A stop that closes a write with at least one data byte starts a busy period of `WR_CYCLES` clocks. During the busy period the block refuses its own address, and afterwards it accepts it again.
- R9: A stop returns the block to idle from any state. A stop after a write that carried no data byte starts no busy period.
- R10: A start in the middle of a transaction restarts device byte decoding. The word address loaded before it is kept, which makes random reads possible.
- R11: After reset the data line is released and every array byte reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sampled from the pin |
| sda_i | input | 1 | Bus data line as sampled from the pin (wired level) |
| dev_sel_i | input | 3 | Strap inputs compared with device byte bits [3:1] |
| wp_i | input | 1 | High protects addresses 0xC00 to 0xFFF from writes |
| sda_low_o | output | 1 | High asks the pad to pull the data line low |

## Verification
Each bus line passes through two synchroniser flip-flops before the edge detector. The state register adds one more stage. As a result, `sda_low_o` moves three clocks after the bus clock edge that causes it. The bench therefore changes its own data level four clocks into each low phase and samples the wired line four clocks into each high phase, well clear of that delay.

The busy period starts two clocks after the stop's rising data edge and lasts `WR_CYCLES` (300 in the bench). The bench probes for a refused address immediately after the stop. It then waits 400 clocks before it expects its address to be accepted again or reads back written data.

// File: rtl/ee_twi_pkg.sv
package ee_twi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK
    } ee_state_t;

endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_m, sda_m, scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_m <= 1'b1;
            sda_m <= 1'b1;
            scl_s <= 1'b1;
            sda_s <= 1'b1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_m <= scl_i;
            sda_m <= sda_i;
            scl_s <= scl_m;
            sda_s <= sda_m;
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s && !scl_p;
        scl_fall  = !scl_s && scl_p;
        start_det = scl_s && scl_p && sda_p && !sda_s;
        stop_det  = scl_s && scl_p && !sda_p && sda_s;
    end

endmodule

// File: rtl/ee_busy_timer.sv
module ee_busy_timer #(
    parameter int unsigned WR_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CNT_W = $clog2(WR_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(WR_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign busy = (cnt != '0);

    // R8
    busy_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
    parameter int unsigned PAGE_BYTES = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [$clog2(PAGE_BYTES)-1:0] wr_idx,
    input  logic [7:0]              wr_data,
    input  logic                    clr,
    output logic [PAGE_BYTES*8-1:0] page_data,
    output logic [PAGE_BYTES-1:0]   page_mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_data <= '0;
            page_mask <= '0;
        end else if (clr) begin
            page_mask <= '0;
        end else if (wr_en) begin
            page_data[wr_idx*8 +: 8] <= wr_data;
            page_mask[wr_idx]        <= 1'b1;
        end
    end

    // R6
    slot_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> page_mask[$past(wr_idx)]);

endmodule

// File: rtl/ee_store.sv
module ee_store #(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned PAGE_BYTES = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [7:0]                    rd_data,
    input  logic                          commit,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] commit_page,
    input  logic [PAGE_BYTES*8-1:0]       page_data,
    input  logic [PAGE_BYTES-1:0]         page_mask,
    input  logic                          wp_i
);
    localparam int unsigned PG_W  = $clog2(PAGE_BYTES);
    localparam int unsigned PN_W  = ADDR_W - PG_W;
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];
    logic       guarded;

    // top quarter of the array is the two highest address bits both set
    assign guarded = wp_i && (commit_page[PN_W-1 -: 2] == 2'b11);
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= 8'h00;
        end else if (commit && !guarded) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (page_mask[i]) mem[{commit_page, PG_W'(i)}] <= page_data[i*8 +: 8];
            end
        end
    end

    // R7
    guarded_page_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && guarded) |=> $stable(mem[{commit_page, PG_W'(0)}]));

endmodule

// File: rtl/eeprom_twi_slave.sv
module eeprom_twi_slave
    import ee_twi_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned PAGE_BYTES = 32,
    parameter int unsigned WR_CYCLES  = 1250000,
    parameter logic [3:0]  FAMILY     = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_sel_i,
    input  logic       wp_i,
    output logic       sda_low_o
);
    localparam int unsigned PG_W = $clog2(PAGE_BYTES);
    localparam int unsigned PN_W = ADDR_W - PG_W;

    ee_state_t         state;
    logic [3:0]        bit_cnt;
    logic [7:0]        rx;
    logic [7:0]        tx;
    logic [ADDR_W-1:0] addr;
    logic              ack_ok, rw, mack, pending;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy, commit, buf_wr, byte_end;
    logic [7:0]              rd_data;
    logic [PAGE_BYTES*8-1:0] page_data;
    logic [PAGE_BYTES-1:0]   page_mask;

    ee_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    ee_busy_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy)
    );

    ee_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .wr_en(buf_wr), .wr_idx(addr[PG_W-1:0]),
        .wr_data(rx), .clr(commit), .page_data(page_data), .page_mask(page_mask)
    );

    ee_store #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr), .rd_data(rd_data),
        .commit(commit), .commit_page(addr[ADDR_W-1:PG_W]),
        .page_data(page_data), .page_mask(page_mask), .wp_i(wp_i)
    );

    assign commit   = stop_det && pending;
    assign byte_end = (bit_cnt == 4'd8);

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            rx      <= '0;
            tx      <= '0;
            addr    <= '0;
            ack_ok  <= 1'b0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            pending <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            pending <= 1'b0;
        end else if (start_det) begin
            state   <= ST_DEV;
            bit_cnt <= '0;
        end else begin
            if (scl_rise) begin
                unique case (state)
                    ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT: begin
                        rx      <= {rx[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    ST_RDAT_ACK: mack <= !sda_s;
                    default: ;
                endcase
            end
            if (scl_fall) begin
                unique case (state)
                    ST_DEV: if (byte_end) begin
                        state  <= ST_DEV_ACK;
                        rw     <= rx[0];
                        ack_ok <= (rx[7:4] == FAMILY) && (rx[3:1] == dev_sel_i) && !busy;
                    end
                    ST_DEV_ACK: begin
                        bit_cnt <= '0;
                        if (!ack_ok)  state <= ST_IDLE;
                        else if (rw) begin
                            state <= ST_RDAT;
                            tx    <= rd_data;
                        end else      state <= ST_AHI;
                    end
                    ST_AHI: if (byte_end) begin
                        state              <= ST_AHI_ACK;
                        addr[ADDR_W-1:8]   <= rx[ADDR_W-9:0];
                        ack_ok             <= 1'b1;
                    end
                    ST_AHI_ACK: begin
                        state   <= ST_ALO;
                        bit_cnt <= '0;
                    end
                    ST_ALO: if (byte_end) begin
                        state     <= ST_ALO_ACK;
                        addr[7:0] <= rx;
                        ack_ok    <= 1'b1;
                    end
                    ST_ALO_ACK, ST_WDAT_ACK: begin
                        state   <= ST_WDAT;
                        bit_cnt <= '0;
                    end
                    ST_WDAT: if (byte_end) begin
                        state            <= ST_WDAT_ACK;
                        addr[PG_W-1:0]   <= addr[PG_W-1:0] + PG_W'(1);
                        pending          <= 1'b1;
                        ack_ok           <= 1'b1;
                    end
                    ST_RDAT: begin
                        if (byte_end) begin
                            state <= ST_RDAT_ACK;
                            addr  <= addr + ADDR_W'(1);
                        end else begin
                            tx <= {tx[6:0], 1'b0};
                        end
                    end
                    ST_RDAT_ACK: begin
                        bit_cnt <= '0;
                        if (mack) begin
                            state <= ST_RDAT;
                            tx    <= rd_data;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_low_o = 1'b0;
        buf_wr    = 1'b0;
        unique case (state)
            ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: sda_low_o = ack_ok;
            ST_RDAT: sda_low_o = !tx[7];
            ST_WDAT: buf_wr = scl_fall && byte_end && !stop_det && !start_det;
            default: ;
        endcase
    end

    // R3
    drive_in_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low_o) |-> !scl_s);

    // R8
    busy_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK && busy) |-> !sda_low_o);

    // R9
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    // R10
    start_to_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_DEV && bit_cnt == 4'd0));

endmodule

// File: tb/eeprom_twi_slave_test.sv
module eeprom_twi_slave_test;

    localparam int WRC  = 300;
    localparam int WAIT = 400;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, SEL, 1'b1};

    // {addr[11:0], data[7:0], wp, expected[7:0]}
    localparam int NV = 8;
    localparam logic [28:0] VEC [NV] = '{
        {12'h000, 8'h5A, 1'b0, 8'h5A},
        {12'h3FF, 8'hC3, 1'b1, 8'hC3},
        {12'hBFF, 8'h11, 1'b1, 8'h11},
        {12'hC00, 8'h77, 1'b1, 8'h00},
        {12'hFFF, 8'h99, 1'b1, 8'h00},
        {12'hFFF, 8'h99, 1'b0, 8'h99},
        {12'hC10, 8'h3C, 1'b0, 8'h3C},
        {12'h800, 8'hA5, 1'b1, 8'hA5}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic [2:0] sel = SEL;
    logic wp = 1'b0;
    logic sda_low_o;
    wire  sda_bus = !(m_low || sda_low_o);

    int total = 0;
    int bad = 0;
    int pulls = 0;
    logic mon_en = 1'b0;
    logic done = 1'b0;

    always #2 clk = !clk;

    eeprom_twi_slave #(.WR_CYCLES(WRC)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .dev_sel_i(sel), .wp_i(wp), .sda_low_o(sda_low_o)
    );

    always @(negedge clk) if (mon_en && sda_low_o) pulls++;

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; wt(4); scl = 1'b1; wt(4); m_low = 1'b1; wt(4); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wt(4); m_low = 1'b1; wt(4); scl = 1'b1; wt(4); m_low = 1'b0; wt(8);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            wt(4); m_low = !b[i]; wt(4); scl = 1'b1; wt(8); scl = 1'b0;
        end
        wt(4); m_low = 1'b0; wt(4); scl = 1'b1; wt(4); ack = !sda_bus; wt(4); scl = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            wt(8); scl = 1'b1; wt(4); d[i] = sda_bus; wt(4); scl = 1'b0;
        end
        wt(4); m_low = give_ack; wt(4); scl = 1'b1; wt(8); scl = 1'b0; wt(4); m_low = 1'b0;
    endtask

    task automatic write_one(input logic [11:0] a, input logic [7:0] d, output logic [3:0] acks);
        bus_start();
        send_byte(DEV_W, acks[3]);
        send_byte({4'h0, a[11:8]}, acks[2]);
        send_byte(a[7:0], acks[1]);
        send_byte(d, acks[0]);
        bus_stop();
    endtask

    // random read: address phase, repeated start, one byte with no-acknowledge
    task automatic read_one(input logic [11:0] a, output logic [7:0] d);
        logic k;
        bus_start();
        send_byte(DEV_W, k);
        send_byte({4'h0, a[11:8]}, k);
        send_byte(a[7:0], k);
        bus_start();
        send_byte(DEV_R, k);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        logic [3:0] acks;
        logic [7:0] d;
        logic k;
        wt(10);
        rst_n = 1'b1;
        wt(10);

        // R11 reset state
        chk("R11 line released", int'(sda_bus), 1);
        read_one(12'h123, d);
        chk("R11 array cleared", int'(d), 8'h00);

        // R1 clocking without a start
        pulls = 0; mon_en = 1'b1;
        send_byte(DEV_W, k);
        send_byte(8'h00, k);
        mon_en = 1'b0;
        chk("R1 no pull before start", pulls, 0);

        // R2 mismatched straps and family
        pulls = 0; mon_en = 1'b1;
        bus_start(); send_byte({4'b1010, 3'b011, 1'b0}, k); bus_stop();
        bus_start(); send_byte({4'b1100, SEL, 1'b0}, k); bus_stop();
        mon_en = 1'b0;
        chk("R2 mismatch never pulls", pulls, 0);
        bus_start(); send_byte(DEV_W, k); bus_stop();
        chk("R2 match acknowledged", int'(k), 1);

        // table of single-byte writes and read-backs (R3, R7)
        for (int v = 0; v < NV; v++) begin
            wp = VEC[v][8];
            write_one(VEC[v][28:17], VEC[v][16:9], acks);
            chk("R3 all four bytes acknowledged", int'(acks), 4'hF);
            wt(WAIT);
            read_one(VEC[v][28:17], d);
            chk("R7 read-back after protect rule", int'(d), int'(VEC[v][7:0]));
            wp = 1'b0;
        end

        // R4 upper nibble of the high address byte ignored
        bus_start(); send_byte(DEV_W, k); send_byte(8'hA1, k); send_byte(8'h23, k);
        send_byte(8'h42, k); bus_stop();
        wt(WAIT);
        read_one(12'h123, d);
        chk("R4 high nibble ignored", int'(d), 8'h42);

        // R8 busy refusal then recovery
        write_one(12'h200, 8'h66, acks);
        bus_start(); send_byte(DEV_W, k); bus_stop();
        chk("R8 refused while busy", int'(k), 0);
        wt(WAIT);
        bus_start(); send_byte(DEV_W, k); bus_stop();
        chk("R8 accepted after busy", int'(k), 1);

        // R9 stop after address only: no busy period
        bus_start(); send_byte(DEV_W, k); send_byte(8'h02, k); bus_stop();
        bus_start(); send_byte(DEV_W, k); bus_stop();
        chk("R9 no write cycle without data", int'(k), 1);
        chk("R9 line released in idle", int'(sda_bus), 1);

        // R6 page wrap: 0x01E, 0x01F, then 0x000, 0x001
        bus_start(); send_byte(DEV_W, k); send_byte(8'h00, k); send_byte(8'h1E, k);
        send_byte(8'hD1, k); send_byte(8'hD2, k); send_byte(8'hD3, k); send_byte(8'hD4, k);
        bus_stop();
        wt(WAIT);
        read_one(12'h01E, d); chk("R6 page byte 0x01E", int'(d), 8'hD1);
        read_one(12'h01F, d); chk("R6 page byte 0x01F", int'(d), 8'hD2);
        read_one(12'h000, d); chk("R6 wrapped to 0x000", int'(d), 8'hD3);
        read_one(12'h001, d); chk("R6 wrapped to 0x001", int'(d), 8'hD4);
        read_one(12'h020, d); chk("R6 next page untouched", int'(d), 8'h00);

        // R5 and R10 sequential read across the top, then current-address read
        bus_start(); send_byte(DEV_W, k); send_byte(8'h0F, k); send_byte(8'hFF, k);
        bus_start(); send_byte(DEV_R, k);
        chk("R10 read address after repeated start", int'(k), 1);
        recv_byte(1'b1, d); chk("R5 byte at 0xFFF", int'(d), 8'h99);
        recv_byte(1'b0, d); chk("R5 rollover to 0x000", int'(d), 8'hD3);
        bus_stop();
        bus_start(); send_byte(DEV_R, k); recv_byte(1'b0, d); bus_stop();
        chk("R5 current-address read", int'(d), 8'hD4);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule